// File: doc/BRIEF.md
# AM824 Isochronous Audio Packet Assembler

The block builds one isochronous audio packet each time it is started. A start pulse captures the packet's setup: event count, channel count, node ID, bus channel, sample-rate code, timestamp and label mode. The block then emits a stream of 32-bit words on consecutive cycles, one word per cycle. The stream holds two isochronous header words, then two common isochronous packet (CIP) header words, then one AM824 payload quadlet for each channel of each event. Byte 31:24 of each word is the first byte on the wire.

Payload quadlets are filled in the same cycle that they appear. The block raises a read strobe on those cycles, and the sample source presents the low and high bytes of the next 16-bit little-endian sample, together with a label byte. A running 8-bit data block counter is stamped into each packet. It then advances by that packet's event count, so a receiver can detect lost blocks.

Top module: `cip_pkt_asm`

## Requirements
- R1: After reset the block is idle, with `valid_o`, `last_o`, `busy_o` and `smp_rd_o` low. The first packet carries a data block count of 0.
- R2: Word 0 of a packet is `(SPEED<<16) | (1<<14) | (iso_chan<<8) | (0xA<<4)`. SPEED is a parameter, default 0.
- R3: Word 1 of a packet carries, in bits 31:16, the payload length in bytes `(events*channels+2)*4`. Its bits 15:0 are zero.
- R4: Word 2 (first CIP word) holds fields from bit 31 down: 2'b00, the 6-bit value node_id[5:0], the 8-bit channel count, 8 zero bits, and the 8-bit data block count.
- R5: Word 3 (second CIP word) holds 2'b10 in bits 31:30, format 0x10 in bits 29:24, the rate code in bits 23:16 (0=32k, 1=44.1k, 2=48k, 3=88.2k, 4=96k, 5=176.4k, 6=192k), and the timestamp in bits 15:0.
- R6: Each payload word k (k counted from 0, event-major with channels inner) is `{label, smp_hi, smp_lo, 8'h00}`, using the inputs in its own cycle. `smp_rd_o` is high on exactly these words.
- R7: When `raw_mode_i` is 1, the label byte of every payload word is 0x40 and `label_i` is ignored.
- R8: The data block count advances by the event count after each packet, modulo 256.
- R9: A packet with zero events is exactly four words long, with a length field of 8. `last_o` is set on its fourth word.
- R10: `last_o` is high only on the final word of a packet. `valid_o` is high on every cycle from word 0 to the last word, and low on the cycle after the last word. A start pulse while busy is ignored, and a setup that changes during a packet does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a packet when idle |
| events_i | input | EVW | Events in the packet |
| chans_i | input | CHW | Channels per event |
| node_id_i | input | 16 | Node ID (low 6 bits used) |
| iso_chan_i | input | 6 | Isochronous channel number |
| rate_i | input | 3 | Sample-rate code |
| raw_mode_i | input | 1 | Force label 0x40 |
| syt_i | input | 16 | Timestamp |
| label_i | input | 8 | Label byte for the current payload word |
| smp_lo_i | input | 8 | Low sample byte |
| smp_hi_i | input | 8 | High sample byte |
| smp_rd_o | output | 1 | Payload word consumes a sample |
| word_o | output | 32 | Output word |
| valid_o | output | 1 | Word valid |
| last_o | output | 1 | Final word of packet |
| busy_o | output | 1 | Packet in progress |

## Verification
The bench sweeps event counts from 0 to 5 against channel counts from 1 to 3, with both label modes. Every word is checked against values the bench computes from arithmetic. The zero-event cases separate the empty-packet path from the payload path.

A run of long single-channel packets drives the block counter past 256 to expose errors in the wrap. A start pulse sent mid-packet, together with changed setup inputs, shows that the setup is captured once at the start. The sample bytes and labels vary per word, so any swap of byte lanes or error in sample order is caught.

// File: rtl/cip_pkg.sv
package cip_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ISO0, PH_ISO1, PH_CIP0, PH_CIP1, PH_DATA
  } phase_t;
  localparam logic [3:0] TCODE_ISO = 4'hA;
  localparam logic [1:0] TAG_CIP   = 2'b01;
  localparam logic [5:0] FMT_AM    = 6'h10;
  localparam logic [7:0] LABEL_RAW = 8'h40;
endpackage

// File: rtl/cip_seq.sv
module cip_seq
  import cip_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] total_i,
  output phase_t        phase_o,
  output logic          last_o,
  output logic          accept_o
);
  phase_t        phase_q, phase_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          data_end;

  assign data_end = (cnt_q == total_i - PW'(1));
  assign accept_o = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_ISO0;
      PH_ISO0: phase_d = PH_ISO1;
      PH_ISO1: phase_d = PH_CIP0;
      PH_CIP0: phase_d = PH_CIP1;
      PH_CIP1: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        phase_d = (total_i == '0) ? PH_IDLE : PH_DATA;
      end
      PH_DATA: begin
        cnt_en = 1'b1;
        if (data_end) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q + PW'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign last_o  = ((phase_q == PH_CIP1) && (total_i == '0)) ||
                   ((phase_q == PH_DATA) && data_end);

  // R10
  hdr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ISO0) |=> (phase_q == PH_ISO1));
  // R10
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/cip_dbc.sv
module cip_dbc #(
  parameter int EVW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv_i,
  input  logic [EVW-1:0] step_i,
  output logic [7:0]     dbc_o
);
  logic [7:0] dbc_q, dbc_d;

  always_comb dbc_d = dbc_q + 8'(step_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dbc_q <= '0;
    else if (adv_i) dbc_q <= dbc_d;
  end

  assign dbc_o = dbc_q;

  // R8
  dbc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(dbc_q));
endmodule

// File: rtl/cip_hdr.sv
module cip_hdr
  import cip_pkg::*;
#(
  parameter int          CHW   = 4,
  parameter int          PW    = 10,
  parameter logic [1:0]  SPEED = 2'd0
) (
  input  logic [PW-1:0]  total_i,
  input  logic [CHW-1:0] chans_i,
  input  logic [5:0]     sid_i,
  input  logic [5:0]     iso_chan_i,
  input  logic [2:0]     rate_i,
  input  logic [15:0]    syt_i,
  input  logic [7:0]     dbc_i,
  output logic [31:0]    iso0_o,
  output logic [31:0]    iso1_o,
  output logic [31:0]    cip0_o,
  output logic [31:0]    cip1_o
);
  logic [15:0] len_bytes;

  always_comb begin
    len_bytes = 16'((32'(total_i) + 32'd2) << 2);
    iso0_o = {14'd0, SPEED, TAG_CIP, iso_chan_i, TCODE_ISO, 4'd0};
    iso1_o = {len_bytes, 16'd0};
    cip0_o = {2'b00, sid_i, 8'(chans_i), 8'd0, dbc_i};
    cip1_o = {2'b10, FMT_AM, 8'(rate_i), syt_i};
  end
endmodule

// File: rtl/cip_pkt_asm.sv
module cip_pkt_asm
  import cip_pkg::*;
#(
  parameter int         EVW   = 6,
  parameter int         CHW   = 4,
  parameter logic [1:0] SPEED = 2'd0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [EVW-1:0] events_i,
  input  logic [CHW-1:0] chans_i,
  input  logic [15:0]    node_id_i,
  input  logic [5:0]     iso_chan_i,
  input  logic [2:0]     rate_i,
  input  logic           raw_mode_i,
  input  logic [15:0]    syt_i,
  input  logic [7:0]     label_i,
  input  logic [7:0]     smp_lo_i,
  input  logic [7:0]     smp_hi_i,
  output logic           smp_rd_o,
  output logic [31:0]    word_o,
  output logic           valid_o,
  output logic           last_o,
  output logic           busy_o
);
  localparam int PW = EVW + CHW;

  logic [EVW-1:0] ev_q;
  logic [CHW-1:0] ch_q;
  logic [5:0]     sid_q, chan_q;
  logic [2:0]     rate_q;
  logic           raw_q;
  logic [15:0]    syt_q;
  logic [PW-1:0]  total_q, total_d;
  logic           accept;
  phase_t         phase;
  logic           last;
  logic [7:0]     dbc;
  logic [31:0]    iso0, iso1, cip0, cip1;
  logic [7:0]     lab;

  always_comb total_d = PW'(events_i) * PW'(chans_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0; ch_q <= '0; sid_q <= '0; chan_q <= '0;
      rate_q <= '0; raw_q <= 1'b0; syt_q <= '0; total_q <= '0;
    end else if (accept) begin
      ev_q    <= events_i;
      ch_q    <= chans_i;
      sid_q   <= node_id_i[5:0];
      chan_q  <= iso_chan_i;
      rate_q  <= rate_i;
      raw_q   <= raw_mode_i;
      syt_q   <= syt_i;
      total_q <= total_d;
    end
  end

  cip_seq #(.PW(PW)) u_seq (
    .clk, .rst_n, .start_i, .total_i(total_q),
    .phase_o(phase), .last_o(last), .accept_o(accept)
  );

  cip_dbc #(.EVW(EVW)) u_dbc (
    .clk, .rst_n, .adv_i(last), .step_i(ev_q), .dbc_o(dbc)
  );

  cip_hdr #(.CHW(CHW), .PW(PW), .SPEED(SPEED)) u_hdr (
    .total_i(total_q), .chans_i(ch_q), .sid_i(sid_q), .iso_chan_i(chan_q),
    .rate_i(rate_q), .syt_i(syt_q), .dbc_i(dbc),
    .iso0_o(iso0), .iso1_o(iso1), .cip0_o(cip0), .cip1_o(cip1)
  );

  assign lab = raw_q ? LABEL_RAW : label_i;

  always_comb begin
    unique case (phase)
      PH_ISO0: word_o = iso0;
      PH_ISO1: word_o = iso1;
      PH_CIP0: word_o = cip0;
      PH_CIP1: word_o = cip1;
      PH_DATA: word_o = {lab, smp_hi_i, smp_lo_i, 8'h00};
      default: word_o = '0;
    endcase
  end

  assign valid_o  = (phase != PH_IDLE);
  assign busy_o   = (phase != PH_IDLE);
  assign smp_rd_o = (phase == PH_DATA);
  assign last_o   = last;

  // R6
  data_lowbyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rd_o |-> (valid_o && word_o[7:0] == 8'h00));
  // R9
  empty_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !smp_rd_o) |-> (word_o[31:30] == 2'b10));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(total_q));
  // R10
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
endmodule

// File: tb/cip_pkt_asm_tb.sv
module cip_pkt_asm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EVW = 6;
  localparam int CHW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [EVW-1:0] events_i;
  logic [CHW-1:0] chans_i;
  logic [15:0] node_id_i, syt_i;
  logic [5:0]  iso_chan_i;
  logic [2:0]  rate_i;
  logic        raw_mode_i;
  logic [7:0]  label_i, smp_lo_i, smp_hi_i;
  logic        smp_rd_o, valid_o, last_o, busy_o;
  logic [31:0] word_o;

  int errs = 0;
  int checks = 0;
  logic [7:0] exp_dbc = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cip_pkt_asm #(.EVW(EVW), .CHW(CHW)) u_dut (
    .clk, .rst_n, .start_i, .events_i, .chans_i, .node_id_i, .iso_chan_i,
    .rate_i, .raw_mode_i, .syt_i, .label_i, .smp_lo_i, .smp_hi_i,
    .smp_rd_o, .word_o, .valid_o, .last_o, .busy_o
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_pkt(input int ev, input int ch, input bit raw,
                         input logic [15:0] node, input logic [5:0] chn,
                         input logic [2:0] rate, input logic [15:0] syt,
                         input bit inject);
    int total;
    logic [31:0] exp;
    logic [7:0] lab;
    total = ev * ch;
    @(negedge clk);
    events_i = EVW'(ev); chans_i = CHW'(ch); node_id_i = node;
    iso_chan_i = chn; rate_i = rate; syt_i = syt; raw_mode_i = raw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int w = 0; w < total + 4; w++) begin
      if (inject && w == 2) begin
        start_i = 1'b1; events_i = EVW'(ev + 1); chans_i = CHW'(ch + 1);
        syt_i = ~syt; iso_chan_i = ~chn;
      end
      if (inject && w == 3) start_i = 1'b0;
      if (w >= 4) begin
        smp_lo_i = 8'((w - 4) * 3 + 1);
        smp_hi_i = 8'((w - 4) ^ 8'h5A);
        label_i  = 8'((w - 4) + 8'h80);
      end
      #1;
      check("R10 valid", {31'd0, valid_o}, 32'd1);
      check("R10 last", {31'd0, last_o}, {31'd0, (w == total + 3)});
      check("R6 rd", {31'd0, smp_rd_o}, {31'd0, (w >= 4)});
      case (w)
        0: exp = (32'd1 << 14) | (32'(chn) << 8) | (32'hA << 4);
        1: exp = 32'((total + 2) * 4) << 16;
        2: exp = (32'(node[5:0]) << 24) | (32'(ch) << 16) | 32'(exp_dbc);
        3: exp = (32'h2 << 30) | (32'h10 << 24) | (32'(rate) << 16) | 32'(syt);
        default: begin
          lab = raw ? 8'h40 : 8'((w - 4) + 8'h80);
          exp = {lab, 8'((w - 4) ^ 8'h5A), 8'((w - 4) * 3 + 1), 8'h00};
        end
      endcase
      case (w)
        0: check("R2 iso0", word_o, exp);
        1: check(total == 0 ? "R9 len" : "R3 len", word_o, exp);
        2: check("R4/R8 cip0", word_o, exp);
        3: check("R5 cip1", word_o, exp);
        default: check(raw ? "R7 raw" : "R6 data", word_o, exp);
      endcase
      @(negedge clk);
    end
    if (inject) begin
      events_i = EVW'(ev); chans_i = CHW'(ch); syt_i = syt; iso_chan_i = chn;
    end
    #1;
    check("R10 end", {30'd0, valid_o, busy_o}, 32'd0);
    exp_dbc = exp_dbc + 8'(ev);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; events_i = '0; chans_i = '0;
    node_id_i = '0; iso_chan_i = '0; rate_i = '0; raw_mode_i = 1'b0;
    syt_i = '0; label_i = '0; smp_lo_i = '0; smp_hi_i = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 reset", {28'd0, valid_o, last_o, busy_o, smp_rd_o}, 32'd0);
    rst_n = 1'b1;
    // R1 first packet dbc=0, zero-event packet (R9)
    run_pkt(0, 2, 1'b0, 16'hFFC5, 6'd3, 3'd2, 16'h1234, 1'b0);
    for (int e = 0; e <= 5; e++)
      for (int c = 1; c <= 3; c++)
        run_pkt(e, c, (e + c) % 2 == 1, 16'(16'h0100 + e * 7 + c),
                6'(e * 11 + c), 3'((e + c) % 7), 16'(e * 4099 + c * 257),
                1'b0);
    // R10 start during a packet is ignored
    run_pkt(3, 2, 1'b0, 16'h003F, 6'd63, 3'd6, 16'hBEEF, 1'b1);
    run_pkt(2, 2, 1'b1, 16'h0011, 6'd9, 3'd4, 16'h0F0F, 1'b1);
    // R8 wrap past 256
    for (int k = 0; k < 6; k++)
      run_pkt(60, 1, 1'b1, 16'h002A, 6'd1, 3'd1, 16'(k * 999), 1'b0);
    run_pkt(0, 1, 1'b0, 16'h0002, 6'd5, 3'd0, 16'hFFFF, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule